// File: doc/BRIEF.md
# Multi-Pair Conversion Start Controller

This block is the start-of-conversion front end for a converter that samples six channels as three pairs. Each pair has its own start line. A mode pin picks between hardware control and software control. In software control, a sequencing bit decides whether the pair-A line starts every selected pair at once or whether each line starts only its own pair.

For each pair, the block keeps a counter that runs on the conversion clock, so that it knows how long the conversion lasts. It drives a busy flag while the pair converts and a one-cycle done strobe when the count ends. Under hardware control, a start line must stay high for the whole conversion. If it falls early, the conversion is aborted and the pair is flagged as partially powered down. The flag stays set until the pair's next launch.

A standby input quiets the whole block. The mode, sequencing and pair-select inputs are static levels, so no register access is needed.

Top module: `pair_start_ctrl`

## Requirements
- R1: After reset, `busy`, `done` and `pd` are all zero.
- R2: With `sw_mode`=0, a rising edge on `start[i]` launches pair i only. `busy[i]` is high for exactly CONV_CYCLES (default 18) clock cycles, starting with the cycle after the edge is sampled.
- R3: With `sw_mode`=0, if `start[i]` is low at a clock edge while `busy[i]` is high, then at that edge `busy[i]` drops, `pd[i]` sets and no done strobe follows.
- R4: On normal completion, `done[i]` is high for exactly one cycle: the first cycle after `busy[i]` falls.
- R5: With `sw_mode`=1 and `seq_mode`=0, a rising edge on `start[0]` launches every pair whose `pair_sel` bit is 1. Edges on `start[1]` and `start[2]` are ignored.
- R6: With `sw_mode`=1 and `seq_mode`=1, each `start[i]` launches only pair i. In either software mode, releasing a start line early neither aborts the conversion nor sets `pd`.
- R7: A rising edge that targets a pair whose `busy` bit is high is ignored. The running conversion keeps its original end time.
- R8: A launch of a pair clears that pair's `pd` bit in the same edge that sets its `busy` bit.
- R9: While `standby_n` is low, all outputs are cleared and start edges are ignored. A start line held high through standby is not taken as an edge when `standby_n` returns high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Conversion clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| standby_n | input | 1 | Low powers the block down |
| sw_mode | input | 1 | 0 selects hardware start control, 1 selects software start control |
| seq_mode | input | 1 | Sequencing bit, used only when sw_mode is 1 |
| pair_sel | input | PAIRS | Pairs started by start[0] in software non-sequenced mode |
| start | input | PAIRS | One start line per pair |
| busy | output | PAIRS | Pair is converting |
| done | output | PAIRS | One-cycle strobe at the end of a normal conversion |
| pd | output | PAIRS | Pair is in partial power-down after an early release |

## Verification
The hardest cases to reach are a rising edge that lands on a pair that is already busy, and a start line that stays high through a standby period. Under hardware control, the first case cannot happen without an early release that aborts the conversion. The stimulus therefore switches to sequenced software mode, releases pair A's line and raises it again mid-conversion, then checks that busy still ends at the first launch's time. For the standby case, the bench powers the block down in the middle of a conversion, raises a fresh line during standby, and keeps both lines high as standby ends, so that any false launch would show up as a busy bit.

// File: rtl/pair_start_ctrl.sv
module pair_start_ctrl #(
  parameter int PAIRS       = 3,
  parameter int CONV_CYCLES = 18
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             standby_n,
  input  logic             sw_mode,
  input  logic             seq_mode,
  input  logic [PAIRS-1:0] pair_sel,
  input  logic [PAIRS-1:0] start,
  output logic [PAIRS-1:0] busy,
  output logic [PAIRS-1:0] done,
  output logic [PAIRS-1:0] pd
);
  localparam int CW = (CONV_CYCLES > 2) ? $clog2(CONV_CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(CONV_CYCLES - 1);

  logic [PAIRS-1:0] start_q, rise, launch;
  logic             gang;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) start_q <= '0;
    else        start_q <= start;

  assign rise   = start & ~start_q;
  assign gang   = sw_mode && !seq_mode;
  assign launch = ~busy & (gang ? ({PAIRS{rise[0]}} & pair_sel) : rise);

  for (genvar i = 0; i < PAIRS; i++) begin : g_pair
    logic          b, d, p;
    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
        b <= 1'b0; d <= 1'b0; p <= 1'b0; cnt <= '0;
      end else if (!standby_n) begin
        b <= 1'b0; d <= 1'b0; p <= 1'b0; cnt <= '0;
      end else begin
        d <= 1'b0;
        if (launch[i]) begin
          b   <= 1'b1;
          p   <= 1'b0;
          cnt <= LAST;
        end else if (b) begin
          if (!sw_mode && !start[i]) begin
            b <= 1'b0;
            p <= 1'b1;
          end else if (cnt == '0) begin
            b <= 1'b0;
            d <= 1'b1;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
      end

    assign busy[i] = b;
    assign done[i] = d;
    assign pd[i]   = p;

    p_done_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
      done[i] |=> !done[i]);

    p_done_after_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done[i]) |-> $past(busy[i]) && !busy[i]);

    p_drop_pd_r3: assert property (@(posedge clk) disable iff (!rst_n)
      busy[i] && standby_n && !sw_mode && !start[i] |=> pd[i] && !busy[i] && !done[i]);

    p_launch_clears_pd_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy[i]) |-> !pd[i]);

    p_busy_holds_r7: assert property (@(posedge clk) disable iff (!rst_n)
      busy[i] && standby_n && (cnt != '0) && (sw_mode || start[i]) |=> busy[i]);

    p_standby_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !standby_n |=> !busy[i] && !done[i] && !pd[i]);
  end
endmodule

// File: tb/pair_start_ctrl_tb.sv
module pair_start_ctrl_tb;
  localparam int N = 18;

  logic       clk = 1'b0;
  logic       rst_n, standby_n, sw_mode, seq_mode;
  logic [2:0] pair_sel, start;
  logic [2:0] busy, done, pd;

  pair_start_ctrl #(.PAIRS(3), .CONV_CYCLES(N)) u_dut (
    .clk(clk), .rst_n(rst_n), .standby_n(standby_n), .sw_mode(sw_mode),
    .seq_mode(seq_mode), .pair_sel(pair_sel), .start(start),
    .busy(busy), .done(done), .pd(pd));

  always #10 clk = ~clk;

  typedef struct { int cyc; logic [2:0] d; logic [2:0] p; } ev_t;
  ev_t q[$];
  int  cyc = 0;
  int  vectors = 0, fails = 0;
  logic [2:0] pdone = '0, ppd = '0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(string req, int act, int exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_ev(int c, logic [2:0] d, logic [2:0] p);
    q.push_back('{c, d, p});
  endtask

  always @(negedge clk) begin
    logic [2:0] nd, np;
    ev_t e;
    if (rst_n) begin
      nd = done & ~pdone;
      np = pd & ~ppd;
      if ((nd | np) != 3'b000) begin
        if (q.size() == 0) begin
          chk("R4/R3 unexpected strobe", {26'd0, nd, np}, 0);
        end else begin
          e = q.pop_front();
          chk("R4 done strobe bits", nd, e.d);
          chk("R3 pd rise bits", np, e.p);
          chk("R2 event cycle", cyc, e.cyc);
        end
      end
    end
    pdone = done;
    ppd   = pd;
  end

  task automatic hw_full(int i);
    logic [2:0] m;
    m = 3'b001 << i;
    start[i] = 1'b1;
    expect_ev(cyc + 1 + N, m, 3'b000);
    step(1);     chk("R2 busy after launch", busy, m);
    step(N - 1); chk("R2 busy in last cycle", busy, m);
    step(1);     chk("R2 busy ended", busy, 0);
                 chk("R4 done in cycle after busy", done, m);
    step(1);     chk("R4 done one cycle only", done, 0);
    start[i] = 1'b0;
    step(2);
  endtask

  task automatic summary;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual hung expected finish");
    summary();
  end

  initial begin
    rst_n = 1'b0; standby_n = 1'b1; sw_mode = 1'b0; seq_mode = 1'b0;
    pair_sel = 3'b000; start = 3'b000;
    step(3);
    rst_n = 1'b1;
    step(1);
    chk("R1 busy reset", busy, 0);
    chk("R1 done reset", done, 0);
    chk("R1 pd reset", pd, 0);

    hw_full(0);
    hw_full(2);

    start[1] = 1'b1;
    step(5);
    start[1] = 1'b0;
    expect_ev(cyc + 1, 3'b000, 3'b010);
    step(1);
    chk("R3 busy dropped", busy, 0);
    chk("R3 pd set", pd, 3'b010);
    step(N);
    chk("R3 pd holds, no done", {done, pd}, {3'b000, 3'b010});

    start[1] = 1'b1;
    expect_ev(cyc + 1 + N, 3'b010, 3'b000);
    step(1);
    chk("R8 pd cleared on launch", pd, 0);
    chk("R8 launch busy", busy, 3'b010);
    step(N + 1);
    start[1] = 1'b0;
    step(2);

    sw_mode = 1'b1; seq_mode = 1'b0; pair_sel = 3'b101;
    start[1] = 1'b1; start[2] = 1'b1;
    step(2);
    chk("R5 B/C ignored", busy, 0);
    start[0] = 1'b1;
    expect_ev(cyc + 1 + N, 3'b101, 3'b000);
    step(1);
    chk("R5 selected pairs busy", busy, 3'b101);
    step(3);
    start[0] = 1'b0;
    step(N);
    chk("R6 no pd in software mode", pd, 0);
    chk("R5 all ended", busy, 0);
    start = 3'b000;
    step(2);

    seq_mode = 1'b1;
    start[1] = 1'b1;
    expect_ev(cyc + 1 + N, 3'b010, 3'b000);
    step(3);
    start[2] = 1'b1;
    expect_ev(cyc + 1 + N, 3'b100, 3'b000);
    step(1);
    chk("R6 own pairs only", busy, 3'b110);
    step(N + 2);
    chk("R6 both ended", busy, 0);
    start = 3'b000;
    step(2);

    start[0] = 1'b1;
    expect_ev(cyc + 1 + N, 3'b001, 3'b000);
    step(3);
    start[0] = 1'b0;
    step(3);
    start[0] = 1'b1;
    step(N - 6);
    chk("R7 still busy at original end", busy, 3'b001);
    step(1);
    chk("R7 ended at original time", busy, 0);
    step(2);
    chk("R7 no relaunch", busy, 0);
    start = 3'b000;
    step(2);

    sw_mode = 1'b0; seq_mode = 1'b0;
    start[2] = 1'b1;
    step(4);
    start[2] = 1'b0;
    expect_ev(cyc + 1, 3'b000, 3'b100);
    step(2);
    start[0] = 1'b1;
    step(5);
    standby_n = 1'b0;
    step(1);
    chk("R9 busy cleared", busy, 0);
    chk("R9 pd cleared", pd, 0);
    step(3);
    start[1] = 1'b1;
    step(2);
    chk("R9 edge ignored in standby", busy, 0);
    standby_n = 1'b1;
    step(3);
    chk("R9 held lines not edges", busy, 0);
    chk("R9 no strobes", {done, pd}, 0);
    start = 3'b000;
    step(2);

    chk("R4 all expected events seen", q.size(), 0);
    summary();
  end
endmodule